// File: doc/BRIEF.md
# Multicast Group Address Hash Filter

This block decides whether a received frame addressed to a group should be kept. It does this by hashing the destination address against a small host-programmed table. While the six destination-address bytes stream in, it runs the Ethernet CRC-32 over them, one byte per clock. The six most significant bits of the resulting CRC register form a hash. That hash picks one bit of a 64-bit table, which is held as eight byte registers that the host writes through a simple byte write port.

When the done strobe arrives after the sixth address byte, the block registers three results: the hash, a flag saying whether the address is a group address, and a pass decision. The pass decision is asserted when the address is a group address and the selected table bit is set. A downstream filter treats this pass as an override that accepts the frame, whatever its other criteria say. The registered results stay unchanged until the next done strobe, so they can be read at leisure while the next frame's address is being hashed.

Top module: `mcast_hash_filter`

## Requirements
- R1: After synchronous reset, `hash` is 0, `is_group` and `grp_pass` are 0, and all 64 table bits are 0, so a group address hashed right after reset yields `grp_pass` = 0.
- R2: The CRC register is preset to all ones by `da_start`. It is then advanced once for each accepted byte using polynomial 0x04C11DB7, taking the data bits least significant first with no final inversion. `hash` is CRC bits 31..26 (hash bit 5 = CRC bit 31). For addresses ED/0D/01/2F followed by five zero bytes, the hashes are 000000, 010000, 100111 and 111111.
- R3: The table bit selected by a hash is bit `hash[2:0]` of table byte `hash[5:3]`. Table byte k is written with `mt_we`=1, `mt_idx`=k, `mt_wdata`.
- R4: `is_group` equals bit 0 of the first accepted address byte. `grp_pass` is 1 exactly when `is_group` is 1 and the selected table bit is 1, so an individual address never passes.
- R5: `hash`, `is_group` and `grp_pass` change only at a clock edge where `da_done` is 1. They take their new values at that edge and hold through any later start and byte activity until the next `da_done`.
- R6: Only the first six bytes with `da_valid`=1 after a start enter the CRC. Further bytes, and a byte presented in the same cycle as `da_start`, are ignored.
- R7: Table writes do not alter the outputs on their own. A later `da_done` evaluates the held CRC against the updated table.
- R8: `da_done` may be repeated without a new start, and each repeat re-evaluates the same address hash against the table as it stands then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| da_start | input | 1 | Begin a new destination address; presets the CRC |
| da_valid | input | 1 | `da_byte` carries an address byte |
| da_byte | input | 8 | Address byte, first byte on the wire first |
| da_done | input | 1 | Address complete; register hash and decision |
| mt_we | input | 1 | Table byte write enable |
| mt_idx | input | 3 | Table byte index |
| mt_wdata | input | 8 | Table byte write data |
| hash | output | 6 | Registered address hash |
| is_group | output | 1 | Registered group-address flag |
| grp_pass | output | 1 | Registered pass decision for group addresses |

## Verification
The hardest situation to reach from the ports is a CRC register that holds steady past its sixth byte while the table changes underneath it. Only then can a stale or late table read, or a counter that fails to saturate, show up. The stimulus feeds seven bytes and checks the hash against the six-byte value. It then rewrites the table with no new start and strobes done again, so the same hash meets a different table bit. The four published address-to-hash pairs pin the bit order and the CRC preset. The remaining vectors are checked against a bit-serial CRC model kept in the bench.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // Advance the CRC register by one byte, data taken least significant bit first.
  function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             valid,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc,
  output logic             group
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] count;
  logic             take;

  assign take = valid && !start && (count < LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc   <= CRC_INIT;
      count <= '0;
      group <= 1'b0;
    end else if (start) begin
      crc   <= CRC_INIT;
      count <= '0;
      group <= 1'b0;
    end else if (take) begin
      crc   <= crc_byte_step(crc, data);
      count <= count + 1'b1;
      if (count == '0) group <= data[0];
    end
  end
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int TBL_BYTES = 8,
  localparam int SEL_W  = $clog2(TBL_BYTES),
  localparam int HASH_W = SEL_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  widx,
  input  logic [7:0]        wdata,
  input  logic [HASH_W-1:0] rhash,
  output logic              rbit
);
  logic [7:0] bytes_q [TBL_BYTES];

  for (genvar b = 0; b < TBL_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                                 bytes_q[b] <= '0;
      else if (we && widx == SEL_W'(b))        bytes_q[b] <= wdata;
    end
  end

  logic [7:0] sel_byte;
  assign sel_byte = bytes_q[rhash[HASH_W-1:3]];
  assign rbit     = sel_byte[rhash[2:0]];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int TBL_BYTES  = 8,
  localparam int SEL_W  = $clog2(TBL_BYTES),
  localparam int HASH_W = SEL_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              da_start,
  input  logic              da_valid,
  input  logic [7:0]        da_byte,
  input  logic              da_done,
  input  logic              mt_we,
  input  logic [SEL_W-1:0]  mt_idx,
  input  logic [7:0]        mt_wdata,
  output logic [HASH_W-1:0] hash,
  output logic              is_group,
  output logic              grp_pass
);
  logic [CRC_W-1:0]  crc;
  logic              group;
  logic [HASH_W-1:0] cur_hash;
  logic              tbl_bit;

  mhf_crc_unit #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk(clk), .rst(rst), .start(da_start), .valid(da_valid),
    .data(da_byte), .crc(crc), .group(group)
  );

  assign cur_hash = crc[CRC_W-1 -: HASH_W];

  mhf_table #(.TBL_BYTES(TBL_BYTES)) u_tbl (
    .clk(clk), .rst(rst), .we(mt_we), .widx(mt_idx), .wdata(mt_wdata),
    .rhash(cur_hash), .rbit(tbl_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hash     <= '0;
      is_group <= 1'b0;
      grp_pass <= 1'b0;
    end else if (da_done) begin
      hash     <= cur_hash;
      is_group <= group;
      grp_pass <= group & tbl_bit;
    end
  end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int HASH_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              da_done,
  input logic              mt_we,
  input logic [HASH_W-1:0] hash,
  input logic              is_group,
  input logic              grp_pass
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      a_r1_reset_clear: assert (hash == '0 && !is_group && !grp_pass)
        else $error("R1 outputs not cleared by reset");
    end
  end

  a_r5_hold_between_done: assert property (@(posedge clk) disable iff (rst)
    !da_done |=> ($stable(hash) && $stable(is_group) && $stable(grp_pass)));

  a_r4_pass_needs_group: assert property (@(posedge clk) disable iff (rst)
    grp_pass |-> is_group);

  a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (mt_we && !da_done) |=> $stable(grp_pass));
endmodule

bind mcast_hash_filter mhf_checker #(.HASH_W(HASH_W)) u_chk (
  .clk(clk), .rst(rst), .da_done(da_done), .mt_we(mt_we),
  .hash(hash), .is_group(is_group), .grp_pass(grp_pass)
);

// File: tb/mcast_hash_filter_test.sv
`timescale 1ns/1ps
module mcast_hash_filter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       da_start = 0, da_valid = 0, da_done = 0, mt_we = 0;
  logic [7:0] da_byte = 0, mt_wdata = 0;
  logic [2:0] mt_idx = 0;
  logic [5:0] hash;
  logic       is_group, grp_pass;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  mcast_hash_filter uut (
    .clk(clk), .rst(rst), .da_start(da_start), .da_valid(da_valid),
    .da_byte(da_byte), .da_done(da_done), .mt_we(mt_we), .mt_idx(mt_idx),
    .mt_wdata(mt_wdata), .hash(hash), .is_group(is_group), .grp_pass(grp_pass)
  );

  localparam int NV = 9;
  localparam logic [47:0] VADDR [NV] = '{
    48'hED0000000000, 48'h0D0000000000, 48'h010000000000, 48'h2F0000000000,
    48'h01005E000001, 48'h01005E000001, 48'h001122334455, 48'h3333000000FB,
    48'hFFFFFFFFFFFF };
  localparam logic [63:0] VTBL [NV] = '{
    64'h0000_0000_0000_0001, 64'h0000_0000_0001_0000, 64'h0000_0080_0000_0000,
    64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'h5555_5555_5555_5555 };
  localparam logic [5:0] KNOWN [4] = '{6'b000000, 6'b010000, 6'b100111, 6'b111111};

  function automatic logic [31:0] ref_crc(input logic [47:0] a, input int n);
    logic [31:0] c;
    logic [7:0]  b;
    c = '1;
    for (int i = 0; i < n; i++) begin
      b = a[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[31] ^ b[j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic logic ref_pass(input logic [47:0] a, input logic [63:0] t);
    logic [5:0] h;
    h = ref_crc(a, 6) >> 26;
    return a[40] & t[h];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [63:0] t);
    for (int k = 0; k < 8; k++) begin
      mt_we = 1; mt_idx = 3'(k); mt_wdata = t[8*k +: 8];
      @(negedge clk);
    end
    mt_we = 0;
  endtask

  task automatic send_addr(input logic [47:0] a, input int nbytes);
    da_start = 1; @(negedge clk); da_start = 0;
    for (int i = 0; i < nbytes; i++) begin
      da_valid = 1; da_byte = (i < 6) ? a[47 - 8*i -: 8] : 8'hAA;
      @(negedge clk);
    end
    da_valid = 0;
  endtask

  task automatic strobe_done();
    da_done = 1; @(negedge clk); da_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 hash", 32'(hash), 0);
    check("R1 pass", 32'(grp_pass), 0);
    send_addr(48'h01005E000001, 6); strobe_done();
    check("R1 table cleared", 32'(grp_pass), 0);
    check("R4 group flag", 32'(is_group), 1);

    // vector table: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      load_table(VTBL[v]);
      send_addr(VADDR[v], 6);
      strobe_done();
      if (v < 4) check("R2 stated hash", 32'(hash), 32'(KNOWN[v]));
      check("R2 hash", 32'(hash), 32'(ref_crc(VADDR[v], 6) >> 26));
      check("R4 group", 32'(is_group), 32'(VADDR[v][40]));
      check("R3 R4 pass", 32'(grp_pass), 32'(ref_pass(VADDR[v], VTBL[v])));
    end

    // R6: seventh byte ignored
    load_table(64'h0);
    send_addr(48'h3333000000FB, 7); strobe_done();
    check("R6 extra byte", 32'(hash), 32'(ref_crc(48'h3333000000FB, 6) >> 26));

    // R6: byte in start cycle ignored
    da_start = 1; da_valid = 1; da_byte = 8'h55; @(negedge clk);
    da_start = 0;
    for (int i = 0; i < 6; i++) begin
      da_byte = VADDR[2][47 - 8*i -: 8]; @(negedge clk);
    end
    da_valid = 0; strobe_done();
    check("R6 start-cycle byte", 32'(hash), 32'(KNOWN[2]));

    // R5 hold through a new address until done
    load_table(64'hFFFF_FFFF_FFFF_FFFF);
    send_addr(48'h2F0000000000, 6); strobe_done();
    check("R5 pass set", 32'(grp_pass), 1);
    send_addr(48'h001122334455, 6);
    check("R5 hash held", 32'(hash), 32'(KNOWN[3]));
    check("R5 pass held", 32'(grp_pass), 1);
    strobe_done();
    check("R5 update at done", 32'(grp_pass), 0);

    // R7 R8: table rewrite alone has no effect; repeated done re-evaluates
    send_addr(48'hED0000000000, 6); strobe_done();
    check("R7 pass before rewrite", 32'(grp_pass), 1);
    load_table(64'hFFFF_FFFF_FFFF_FFFE);
    check("R7 write no effect", 32'(grp_pass), 1);
    strobe_done();
    check("R8 repeat done", 32'(grp_pass), 0);
    check("R8 hash same", 32'(hash), 32'(KNOWN[0]));

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule